// File: doc/BRIEF.md
# Power-Up Memory Initialization Sequencer

This block loads a DSP core's on-chip memories after reset is released. It works through three jobs in a fixed order. First it copies the program boot ROM into program RAM. Next it copies the parameter boot ROM into parameter RAM, which holds all zeros until then. Last it writes zero to every data-memory word.

All three jobs fit inside one start-up window of a fixed length, counted in master-clock cycles. At the start of the window the block samples the 3-bit clock-mode strap pins and holds that value until the next reset. When the window ends it raises a ready flag, which tells the rest of the chip that host register access may begin.

The release of the active-low reset first passes through two flops clocked on the falling clock edge. Only the output of that synchronizer starts the window. Asserting reset again at any time stops the sequence at once. Each ROM is a synchronous array with one cycle of read latency. Each RAM takes a single write port with enable, address and data.

Top module: `boot_init_seq`

## Requirements
- R1: While `rst_ni` is low, `ready_o`, every RAM write enable and every ROM read enable are 0, and `mode_o` is 3'b000, whatever `mode_pins_i` does.
- R2: After `rst_ni` rises, the sequencer stays idle through the first falling clock edge. It starts at the second falling edge: at that edge `prog_rom_re_o` goes to 1 with `prog_rom_addr_o` = 0.
- R3: `ready_o` rises after exactly WINDOW_CYCLES (default 8192) rising clock edges, counted from the internal start in R2. It stays at 1 until `rst_ni` goes low.
- R4: Each program RAM address 0..PROG_WORDS-1 is written exactly once. The data written is the program ROM word at the same address, and that word is returned one cycle after its read.
- R5: Each parameter RAM address 0..PAR_WORDS-1 is written exactly once with the parameter ROM word at the same address. This replaces whatever the RAM held before.
- R6: Each data RAM address 0..DAT_WORDS-1 is written exactly once, with the value 0.
- R7: Every program write happens before any parameter write, and every parameter write happens before any data write. Within each job the addresses rise by one per cycle.
- R8: `mode_o` takes the value of `mode_pins_i` at the first rising edge after the internal start. Later changes on the pins have no effect until the next reset.
- R9: Driving `rst_ni` low in the middle of the window drops all write enables and `ready_o` at once, without waiting for a clock edge. The next release runs the whole sequence again from address 0.
- R10: A RAM write enable is never high while `ready_o` is high or `rst_ni` is low. At most one of the three write enables is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_pins_i | input | 3 | Clock-mode strap pins |
| mode_o | output | 3 | Mode value captured at start |
| ready_o | output | 1 | Initialization window finished |
| prog_rom_re_o | output | 1 | Program ROM read enable |
| prog_rom_addr_o | output | PROG_AW | Program ROM read address |
| prog_rom_data_i | input | PROG_DW | Program ROM read data, one cycle after the read |
| par_rom_re_o | output | 1 | Parameter ROM read enable |
| par_rom_addr_o | output | PAR_AW | Parameter ROM read address |
| par_rom_data_i | input | PAR_DW | Parameter ROM read data, one cycle after the read |
| prog_ram_we_o | output | 1 | Program RAM write enable |
| prog_ram_addr_o | output | PROG_AW | Program RAM write address |
| prog_ram_wdata_o | output | PROG_DW | Program RAM write data |
| par_ram_we_o | output | 1 | Parameter RAM write enable |
| par_ram_addr_o | output | PAR_AW | Parameter RAM write address |
| par_ram_wdata_o | output | PAR_DW | Parameter RAM write data |
| dat_ram_we_o | output | 1 | Data RAM write enable |
| dat_ram_addr_o | output | DAT_AW | Data RAM write address |
| dat_ram_wdata_o | output | DAT_DW | Data RAM write data |

## Verification
Some properties are checked on every clock edge:
- the quiet state during reset;
- that `ready_o` stays high once raised and that no write happens after it;
- that at most one write enable is high at a time;
- that `mode_o` is held;
- the one-cycle link from each ROM read to its RAM write;
- the address step of one in the program job.

Other behaviour needs the bench's scenarios: the exact cycle of the falling-edge start, the exact window length, the content and visit count of every RAM word, the order of the three jobs, and a full clean restart after an abort in mid-window.

// File: rtl/boot_init_pkg.sv
package boot_init_pkg;
  typedef enum logic [1:0] {
    JOB_PROG = 2'd0,
    JOB_PAR  = 2'd1,
    JOB_DAT  = 2'd2,
    JOB_IDLE = 2'd3
  } job_e;

  localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/boot_rst_sync.sv
// Reset release is retimed to the falling clock edge; assertion stays asynchronous.
module boot_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/boot_window_ctr.sv
module boot_window_ctr #(
  parameter int unsigned WINDOW_CYCLES = 8192,
  localparam int unsigned CW = $clog2(WINDOW_CYCLES) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          active_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (active_o) cnt_q <= cnt_q + 1'b1;
  end

  assign active_o = rst_ni && (cnt_q < CW'(WINDOW_CYCLES));
  assign done_o   = (cnt_q == CW'(WINDOW_CYCLES));
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/boot_job_decode.sv
// Maps the window count onto program, parameter and data-clear slots, back to back.
module boot_job_decode
  import boot_init_pkg::*;
#(
  parameter int unsigned CW        = 14,
  parameter int unsigned PROG_WORDS = 1024,
  parameter int unsigned PAR_WORDS  = 1024,
  parameter int unsigned DAT_WORDS  = 2048,
  localparam int unsigned PROG_AW = $clog2(PROG_WORDS),
  localparam int unsigned PAR_AW  = $clog2(PAR_WORDS),
  localparam int unsigned DAT_AW  = $clog2(DAT_WORDS),
  localparam int unsigned PAR_BASE = PROG_WORDS,
  localparam int unsigned DAT_BASE = PROG_WORDS + PAR_WORDS,
  localparam int unsigned JOB_END  = PROG_WORDS + PAR_WORDS + DAT_WORDS
) (
  input  logic [CW-1:0]      cnt_i,
  input  logic               active_i,
  output job_e               job_o,
  output logic [PROG_AW-1:0] prog_addr_o,
  output logic [PAR_AW-1:0]  par_addr_o,
  output logic [DAT_AW-1:0]  dat_addr_o
);
  always_comb begin
    if (!active_i)                     job_o = JOB_IDLE;
    else if (cnt_i < CW'(PAR_BASE))    job_o = JOB_PROG;
    else if (cnt_i < CW'(DAT_BASE))    job_o = JOB_PAR;
    else if (cnt_i < CW'(JOB_END))     job_o = JOB_DAT;
    else                               job_o = JOB_IDLE;
  end

  assign prog_addr_o = PROG_AW'(cnt_i);
  assign par_addr_o  = PAR_AW'(cnt_i - CW'(PAR_BASE));
  assign dat_addr_o  = DAT_AW'(cnt_i - CW'(DAT_BASE));
endmodule

// File: rtl/boot_wr_stage.sv
// One-cycle alignment of address/enable with synchronous ROM read data.
module boot_wr_stage #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          vld_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_i;
      addr_q <= addr_i;
    end
  end

  assign we_o   = vld_q && rst_ni;
  assign addr_o = addr_q;
  assign data_o = data_i;
endmodule

// File: rtl/boot_init_seq.sv
module boot_init_seq
  import boot_init_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 8192,
  parameter int unsigned PROG_WORDS    = 1024,
  parameter int unsigned PROG_DW       = 32,
  parameter int unsigned PAR_WORDS     = 1024,
  parameter int unsigned PAR_DW        = 28,
  parameter int unsigned DAT_WORDS     = 2048,
  parameter int unsigned DAT_DW        = 24,
  localparam int unsigned PROG_AW = $clog2(PROG_WORDS),
  localparam int unsigned PAR_AW  = $clog2(PAR_WORDS),
  localparam int unsigned DAT_AW  = $clog2(DAT_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MODE_W-1:0]  mode_pins_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic               ready_o,
  output logic               prog_rom_re_o,
  output logic [PROG_AW-1:0] prog_rom_addr_o,
  input  logic [PROG_DW-1:0] prog_rom_data_i,
  output logic               par_rom_re_o,
  output logic [PAR_AW-1:0]  par_rom_addr_o,
  input  logic [PAR_DW-1:0]  par_rom_data_i,
  output logic               prog_ram_we_o,
  output logic [PROG_AW-1:0] prog_ram_addr_o,
  output logic [PROG_DW-1:0] prog_ram_wdata_o,
  output logic               par_ram_we_o,
  output logic [PAR_AW-1:0]  par_ram_addr_o,
  output logic [PAR_DW-1:0]  par_ram_wdata_o,
  output logic               dat_ram_we_o,
  output logic [DAT_AW-1:0]  dat_ram_addr_o,
  output logic [DAT_DW-1:0]  dat_ram_wdata_o
);
  localparam int unsigned CW = $clog2(WINDOW_CYCLES) + 1;

  logic              rst_int_n;
  logic [CW-1:0]     cnt;
  logic              active;
  logic              done;
  job_e              job;
  logic [PROG_AW-1:0] prog_addr;
  logic [PAR_AW-1:0]  par_addr;
  logic [DAT_AW-1:0]  dat_addr;
  logic [MODE_W-1:0]  mode_q;
  logic               cap_q;

  boot_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  boot_window_ctr #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .cnt_o    (cnt),
    .active_o (active),
    .done_o   (done)
  );

  boot_job_decode #(
    .CW(CW), .PROG_WORDS(PROG_WORDS), .PAR_WORDS(PAR_WORDS), .DAT_WORDS(DAT_WORDS)
  ) u_dec (
    .cnt_i       (cnt),
    .active_i    (active),
    .job_o       (job),
    .prog_addr_o (prog_addr),
    .par_addr_o  (par_addr),
    .dat_addr_o  (dat_addr)
  );

  // Strap pins sampled once per reset release.
  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= '0;
      cap_q  <= 1'b0;
    end else if (active && !cap_q) begin
      mode_q <= mode_pins_i;
      cap_q  <= 1'b1;
    end
  end

  assign mode_o  = mode_q;
  assign ready_o = done && rst_int_n;

  assign prog_rom_re_o   = (job == JOB_PROG);
  assign prog_rom_addr_o = prog_addr;
  assign par_rom_re_o    = (job == JOB_PAR);
  assign par_rom_addr_o  = par_addr;

  boot_wr_stage #(.AW(PROG_AW), .DW(PROG_DW)) u_prog_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .vld_i  (job == JOB_PROG),
    .addr_i (prog_addr),
    .data_i (prog_rom_data_i),
    .we_o   (prog_ram_we_o),
    .addr_o (prog_ram_addr_o),
    .data_o (prog_ram_wdata_o)
  );

  boot_wr_stage #(.AW(PAR_AW), .DW(PAR_DW)) u_par_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .vld_i  (job == JOB_PAR),
    .addr_i (par_addr),
    .data_i (par_rom_data_i),
    .we_o   (par_ram_we_o),
    .addr_o (par_ram_addr_o),
    .data_o (par_ram_wdata_o)
  );

  boot_wr_stage #(.AW(DAT_AW), .DW(DAT_DW)) u_dat_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .vld_i  (job == JOB_DAT),
    .addr_i (dat_addr),
    .data_i ('0),
    .we_o   (dat_ram_we_o),
    .addr_o (dat_ram_addr_o),
    .data_o (dat_ram_wdata_o)
  );
endmodule

// File: rtl/boot_init_seq_chk.sv
module boot_init_seq_chk #(
  parameter int unsigned PROG_AW = 10,
  parameter int unsigned PAR_AW  = 10,
  parameter int unsigned DAT_AW  = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         mode_o,
  input logic               ready_o,
  input logic               prog_rom_re_o,
  input logic [PROG_AW-1:0] prog_rom_addr_o,
  input logic               par_rom_re_o,
  input logic [PAR_AW-1:0]  par_rom_addr_o,
  input logic               prog_ram_we_o,
  input logic [PROG_AW-1:0] prog_ram_addr_o,
  input logic               par_ram_we_o,
  input logic [PAR_AW-1:0]  par_ram_addr_o,
  input logic               dat_ram_we_o
);
  logic any_we;
  assign any_we = prog_ram_we_o || par_ram_we_o || dat_ram_we_o;

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!ready_o && !any_we && !prog_rom_re_o && !par_rom_re_o && mode_o == 3'b000));

  assert_ready_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  assert_prog_from_rom_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_ram_we_o |-> ($past(prog_rom_re_o) && prog_ram_addr_o == $past(prog_rom_addr_o)));

  assert_par_from_rom_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_ram_we_o |-> ($past(par_rom_re_o) && par_ram_addr_o == $past(par_rom_addr_o)));

  assert_prog_ascend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_ram_we_o && $past(prog_ram_we_o)) |-> prog_ram_addr_o == $past(prog_ram_addr_o) + 1'b1);

  assert_par_after_prog_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_ram_we_o |-> !prog_rom_re_o);

  assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $stable(mode_o));

  assert_no_we_after_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !any_we);

  assert_single_we_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_ram_we_o, par_ram_we_o, dat_ram_we_o}));
endmodule

bind boot_init_seq boot_init_seq_chk #(
  .PROG_AW(PROG_AW), .PAR_AW(PAR_AW), .DAT_AW(DAT_AW)
) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mode_o          (mode_o),
  .ready_o         (ready_o),
  .prog_rom_re_o   (prog_rom_re_o),
  .prog_rom_addr_o (prog_rom_addr_o),
  .par_rom_re_o    (par_rom_re_o),
  .par_rom_addr_o  (par_rom_addr_o),
  .prog_ram_we_o   (prog_ram_we_o),
  .prog_ram_addr_o (prog_ram_addr_o),
  .par_ram_we_o    (par_ram_we_o),
  .par_ram_addr_o  (par_ram_addr_o),
  .dat_ram_we_o    (dat_ram_we_o)
);

// File: tb/boot_init_seq_tb_top.sv
`timescale 1ns/1ps
module boot_init_seq_tb_top;
  localparam int WIN   = 8192;
  localparam int PW    = 1024;
  localparam int PDW   = 32;
  localparam int QW    = 1024;
  localparam int QDW   = 28;
  localparam int DWD   = 2048;
  localparam int DDW   = 24;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic [2:0] mode_pins_i = 3'b000;
  logic [2:0] mode_o;
  logic ready_o;
  logic prog_rom_re_o, par_rom_re_o;
  logic [9:0] prog_rom_addr_o, par_rom_addr_o;
  logic [PDW-1:0] prog_rom_data_i = '0;
  logic [QDW-1:0] par_rom_data_i = '0;
  logic prog_ram_we_o, par_ram_we_o, dat_ram_we_o;
  logic [9:0] prog_ram_addr_o, par_ram_addr_o;
  logic [10:0] dat_ram_addr_o;
  logic [PDW-1:0] prog_ram_wdata_o;
  logic [QDW-1:0] par_ram_wdata_o;
  logic [DDW-1:0] dat_ram_wdata_o;

  always #2 clk_i = ~clk_i;

  boot_init_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_pins_i(mode_pins_i), .mode_o(mode_o),
    .ready_o(ready_o),
    .prog_rom_re_o(prog_rom_re_o), .prog_rom_addr_o(prog_rom_addr_o), .prog_rom_data_i(prog_rom_data_i),
    .par_rom_re_o(par_rom_re_o), .par_rom_addr_o(par_rom_addr_o), .par_rom_data_i(par_rom_data_i),
    .prog_ram_we_o(prog_ram_we_o), .prog_ram_addr_o(prog_ram_addr_o), .prog_ram_wdata_o(prog_ram_wdata_o),
    .par_ram_we_o(par_ram_we_o), .par_ram_addr_o(par_ram_addr_o), .par_ram_wdata_o(par_ram_wdata_o),
    .dat_ram_we_o(dat_ram_we_o), .dat_ram_addr_o(dat_ram_addr_o), .dat_ram_wdata_o(dat_ram_wdata_o)
  );

  function automatic logic [PDW-1:0] prog_val(int a);
    return PDW'(a * 32'h9E37_79B1) ^ 32'h5A5A_0001;
  endfunction
  function automatic logic [QDW-1:0] par_val(int a);
    return QDW'(a * 7 + 3) | 28'h800_0000;
  endfunction

  // synchronous ROM models
  always @(posedge clk_i) begin
    if (prog_rom_re_o) prog_rom_data_i <= prog_val(int'(prog_rom_addr_o));
    if (par_rom_re_o)  par_rom_data_i  <= par_val(int'(par_rom_addr_o));
  end

  logic [PDW-1:0] prog_ram [PW];
  logic [QDW-1:0] par_ram  [QW];
  logic [DDW-1:0] dat_ram  [DWD];
  int prog_hits [PW];
  int par_hits  [QW];
  int dat_hits  [DWD];
  int cyc = 0;
  int last_prog = -1, first_par = -1, last_par = -1, first_dat = -1;
  int bad_we = 0;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if ((prog_ram_we_o || par_ram_we_o || dat_ram_we_o) && (ready_o || !rst_ni)) bad_we <= bad_we + 1;
    if (prog_ram_we_o) begin
      prog_ram[prog_ram_addr_o] <= prog_ram_wdata_o;
      prog_hits[prog_ram_addr_o] <= prog_hits[prog_ram_addr_o] + 1;
      last_prog <= cyc;
    end
    if (par_ram_we_o) begin
      par_ram[par_ram_addr_o] <= par_ram_wdata_o;
      par_hits[par_ram_addr_o] <= par_hits[par_ram_addr_o] + 1;
      if (first_par < 0) first_par <= cyc;
      last_par <= cyc;
    end
    if (dat_ram_we_o) begin
      dat_ram[dat_ram_addr_o] <= dat_ram_wdata_o;
      dat_hits[dat_ram_addr_o] <= dat_hits[dat_ram_addr_o] + 1;
      if (first_dat < 0) first_dat <= cyc;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prefill(input int seed);
    for (int i = 0; i < PW; i++) begin prog_ram[i] = PDW'(seed + i); prog_hits[i] = 0; end
    for (int i = 0; i < QW; i++) begin par_ram[i] = QDW'(seed ^ i); par_hits[i] = 0; end
    for (int i = 0; i < DWD; i++) begin dat_ram[i] = DDW'(seed * 3 + i + 1); dat_hits[i] = 0; end
    last_prog = -1; first_par = -1; last_par = -1; first_dat = -1; bad_we = 0;
  endtask

  task automatic check_mems(input string tag);
    int bad_p = 0, bad_q = 0, bad_d = 0, hit_p = 0, hit_q = 0, hit_d = 0;
    for (int i = 0; i < PW; i++) begin
      if (prog_ram[i] !== prog_val(i)) bad_p++;
      if (prog_hits[i] != 1) hit_p++;
    end
    for (int i = 0; i < QW; i++) begin
      if (par_ram[i] !== par_val(i)) bad_q++;
      if (par_hits[i] != 1) hit_q++;
    end
    for (int i = 0; i < DWD; i++) begin
      if (dat_ram[i] !== '0) bad_d++;
      if (dat_hits[i] != 1) hit_d++;
    end
    chk(bad_p == 0, {"R4 program content ", tag}, bad_p, 0);
    chk(hit_p == 0, {"R4 program once ", tag}, hit_p, 0);
    chk(bad_q == 0, {"R5 parameter content ", tag}, bad_q, 0);
    chk(hit_q == 0, {"R5 parameter once ", tag}, hit_q, 0);
    chk(bad_d == 0, {"R6 data cleared ", tag}, bad_d, 0);
    chk(hit_d == 0, {"R6 data once ", tag}, hit_d, 0);
    chk(last_prog >= 0 && last_prog < first_par, {"R7 program before parameter ", tag}, first_par, last_prog + 1);
    chk(last_par >= 0 && last_par < first_dat, {"R7 parameter before data ", tag}, first_dat, last_par + 1);
    chk(bad_we == 0, {"R10 writes outside window ", tag}, bad_we, 0);
  endtask

  // Called with rst_ni low, just after a rising edge.
  task automatic t_boot(input logic [2:0] mode, input int seed, input string tag);
    prefill(seed);
    mode_pins_i = mode;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(prog_rom_re_o == 1'b0, {"R2 idle after first fall ", tag}, prog_rom_re_o, 0);
    @(negedge clk_i); #1;
    chk(prog_rom_re_o == 1'b1 && prog_rom_addr_o == 0, {"R2 start at second fall ", tag},
        {prog_rom_re_o, prog_rom_addr_o}, 11'h400);
    repeat (5) @(posedge clk_i);
    #1 chk(mode_o == mode, {"R8 mode captured ", tag}, mode_o, mode);
    mode_pins_i = ~mode;
    repeat (WIN - 6) @(posedge clk_i);
    #1 chk(ready_o == 1'b0, {"R3 not ready one edge early ", tag}, ready_o, 0);
    @(posedge clk_i);
    #1 chk(ready_o == 1'b1, {"R3 ready at window end ", tag}, ready_o, 1);
    repeat (20) @(posedge clk_i);
    #1 chk(ready_o == 1'b1, {"R3 ready held ", tag}, ready_o, 1);
    chk(mode_o == mode, {"R8 pin change ignored ", tag}, mode_o, mode);
    check_mems(tag);
    rst_ni = 1'b0;
    #1 chk(ready_o == 1'b0 && mode_o == 3'b000, {"R1 reset clears ", tag}, {ready_o, mode_o}, 0);
    @(posedge clk_i);
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 6; i++) begin
      mode_pins_i = 3'(i);
      @(posedge clk_i); #1;
      chk(!ready_o && !prog_ram_we_o && !par_ram_we_o && !dat_ram_we_o && !prog_rom_re_o && !par_rom_re_o,
          "R1 outputs quiet in reset",
          {ready_o, prog_ram_we_o, par_ram_we_o, dat_ram_we_o, prog_rom_re_o, par_rom_re_o}, 0);
      chk(mode_o == 3'b000, "R1 mode zero in reset", mode_o, 0);
    end
  endtask

  task automatic t_abort();
    prefill(77);
    mode_pins_i = 3'b110;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    repeat (1500) @(posedge clk_i);
    #1 chk(par_ram_we_o == 1'b1, "R9 mid parameter job before abort", par_ram_we_o, 1);
    rst_ni = 1'b0;
    #0.5;
    chk(!par_ram_we_o && !prog_ram_we_o && !dat_ram_we_o && !ready_o, "R9 abort drops enables",
        {par_ram_we_o, prog_ram_we_o, dat_ram_we_o, ready_o}, 0);
    chk(mode_o == 3'b000 && !par_rom_re_o, "R9 abort clears mode and reads", {mode_o, par_rom_re_o}, 0);
    repeat (10) @(posedge clk_i);
    #1 chk(bad_we == 0, "R10 no write during reset after abort", bad_we, 0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    t_reset_state();
    t_boot(3'b101, 11, "boot1");
    t_abort();
    t_boot(3'b011, 29, "after_abort");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule